// File: doc/BRIEF.md
# Dual-Drive PIO Timing Register Bank

This block is the slave-side register file of a two-drive disk interface timing controller. It sits on an 8-bit I/O bus with eight byte offsets. Its configuration registers are hidden: a key byte written to the lock offset opens them, and a second key byte closes them again. While the block is closed, the configuration offsets read as all ones and ignore writes.

Once the block is open, software writes two pairs of timing bytes, one pair per bank (A and B). Each pair has a read-cycle byte and a write-cycle byte. Every timing byte packs an active-pulse count minus one in its upper nibble and a recovery count minus two in its lower nibble. A misc register does two jobs. Its bit 0 picks the bank that the timing offsets reach, and its upper fields carry the shared address-setup count, the ready-wait count and a read-prefetch enable. A control register enables access to bank B and chooses whether drive 1 follows bank B or shares bank A with drive 0. The block decodes the bank selected for each drive into plain clock counts for a strobe generator.

Top module: `pio_timing_bank`

## Requirements
- R1: After reset the block is closed. All four timing bytes hold 0xFF, and control and misc hold 0x00. Both drives therefore output an active count of 16 and a recovery count of 17. The outputs also show a setup count of 1, a ready-wait count of 2 and prefetch off.
- R2: Writing 0x03 to offset 2 opens configuration access, and writing 0x83 to offset 2 closes it. Any other value written to offset 2 leaves the open/closed state unchanged.
- R3: While closed, writes to offsets 0, 1, 3, 5 and 6 change no register, and every read returns 0xFF.
- R4: Offsets 0 (read-cycle byte) and 1 (write-cycle byte) reach bank B only when control bit 7 is 1 and misc bit 0 is 1. In every other case they reach bank A.
- R5: While open, reads of offsets 0 and 1 return the byte of the bank chosen as in R4, and reads of offsets 3 and 6 return the stored control and misc bytes.
- R6: Drive 0 always uses bank A. Drive 1 uses bank B when control bit 0 is 1, and bank A otherwise.
- R7: For each drive, the active count is the upper nibble of its timing byte plus 1 (range 1 to 16). The recovery count is the lower nibble plus 2 (range 2 to 17). The read-cycle and write-cycle bytes are decoded separately.
- R8: The setup count is misc bits 5:4 plus 1. The ready-wait count is misc bits 2:1 plus 2. Prefetch enable is misc bit 6.
- R9: While open, a read of offset 5 returns the strap input pins. Writes to offset 5 have no effect.
- R10: Offsets 2, 4 and 7 always read 0xFF, and writes to offsets 4 and 7 have no effect. With the read enable low, the read bus shows 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 3 | Byte offset from the base address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read enable |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from the offset |
| strapPins | input | 8 | Board strap value shown at offset 5 |
| rdActiveClks | output | 2x5 | Read active count per drive |
| rdRecoverClks | output | 2x5 | Read recovery count per drive |
| wrActiveClks | output | 2x5 | Write active count per drive |
| wrRecoverClks | output | 2x5 | Write recovery count per drive |
| setupClks | output | 3 | Shared address-setup count |
| drdyClks | output | 3 | Shared ready-wait count |
| prefetchEn | output | 1 | Read prefetch enable |

## Verification
A write is taken on the rising edge that sees busWrEn high. Both the register and its decoded counts change right after that edge, so they are due at the next falling edge, where the bench samples them. Reads are combinational, so the bench drives the offset and the read enable at a falling edge and samples two nanoseconds later, well before the next rising edge. Opening and closing take effect on the edge that takes the key byte. The first read after a key write therefore already shows the new state.

// File: rtl/pio_bank_pkg.sv
package pio_bank_pkg;
  localparam int BusW      = 8;
  localparam int OffW      = 3;
  localparam int NibW      = BusW / 2;
  localparam int ClkW      = NibW + 1;
  localparam int NumBanks  = 2;
  localparam int NumDrives = 2;
  localparam int BankW     = $clog2(NumBanks);
  localparam int FieldW    = 2;
  localparam int CntW      = FieldW + 1;

  localparam logic [OffW-1:0] OffTimRd = 3'd0;
  localparam logic [OffW-1:0] OffTimWr = 3'd1;
  localparam logic [OffW-1:0] OffLock  = 3'd2;
  localparam logic [OffW-1:0] OffCtrl  = 3'd3;
  localparam logic [OffW-1:0] OffStrap = 3'd5;
  localparam logic [OffW-1:0] OffMisc  = 3'd6;

  localparam logic [BusW-1:0] KeyOpen   = 8'h03;
  localparam logic [BusW-1:0] KeyClose  = 8'h83;
  localparam logic [BusW-1:0] IdleRead  = 8'hFF;
  localparam logic [BusW-1:0] TimReset  = 8'hFF;
  localparam logic [BusW-1:0] RegReset  = 8'h00;

  localparam int CtrlSplitBit = 0;
  localparam int CtrlBankBEn  = 7;
  localparam int MiscBankBit  = 0;
  localparam int MiscDrdyLo   = 1;
  localparam int MiscSetupLo  = 4;
  localparam int MiscPrefBit  = 6;

  typedef enum logic [2:0] {
    SelNone, SelTimRd, SelTimWr, SelCtrl, SelStrap, SelMisc
  } rd_sel_e;

  typedef struct packed {
    logic    open;
    logic    wrTimRd;
    logic    wrTimWr;
    logic    wrCtrl;
    logic    wrMisc;
    rd_sel_e rdSel;
  } strobe_t;

  function automatic logic [ClkW-1:0] activeOf(input logic [NibW-1:0] nib);
    return ClkW'(nib) + ClkW'(1);
  endfunction

  function automatic logic [ClkW-1:0] recoverOf(input logic [NibW-1:0] nib);
    return ClkW'(nib) + ClkW'(2);
  endfunction
endpackage

// File: rtl/pio_bank_ctrl.sv
module pio_bank_ctrl
  import pio_bank_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OffW-1:0] busAddr,
  input  logic            busWrEn,
  input  logic            busRdEn,
  input  logic [BusW-1:0] busWrData,
  output strobe_t         strb
);
  logic openQ;
  logic keyWrite;

  assign keyWrite = busWrEn && (busAddr == OffLock);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openQ <= 1'b0;
    end else if (keyWrite) begin
      if (busWrData == KeyOpen)       openQ <= 1'b1;
      else if (busWrData == KeyClose) openQ <= 1'b0;
    end
  end

  always_comb begin
    strb       = '0;
    strb.open  = openQ;
    strb.rdSel = SelNone;
    if (openQ && busWrEn) begin
      case (busAddr)
        OffTimRd: strb.wrTimRd = 1'b1;
        OffTimWr: strb.wrTimWr = 1'b1;
        OffCtrl:  strb.wrCtrl  = 1'b1;
        OffMisc:  strb.wrMisc  = 1'b1;
        default:  ;
      endcase
    end
    if (openQ && busRdEn) begin
      case (busAddr)
        OffTimRd: strb.rdSel = SelTimRd;
        OffTimWr: strb.rdSel = SelTimWr;
        OffCtrl:  strb.rdSel = SelCtrl;
        OffStrap: strb.rdSel = SelStrap;
        OffMisc:  strb.rdSel = SelMisc;
        default:  strb.rdSel = SelNone;
      endcase
    end
  end

  // R2
  lock_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrite && busWrData == KeyOpen) |=> openQ);
  // R2
  lock_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrite && busWrData == KeyClose) |=> !openQ);
  // R2
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(keyWrite && (busWrData == KeyOpen || busWrData == KeyClose)))
      |=> (openQ == $past(openQ)));
endmodule

// File: rtl/pio_bank_dp.sv
module pio_bank_dp
  import pio_bank_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strb,
  input  logic [BusW-1:0]                 wrData,
  input  logic [BusW-1:0]                 strapPins,
  output logic [BusW-1:0]                 rdData,
  output logic [NumDrives-1:0][ClkW-1:0]  rdActive,
  output logic [NumDrives-1:0][ClkW-1:0]  rdRecover,
  output logic [NumDrives-1:0][ClkW-1:0]  wrActive,
  output logic [NumDrives-1:0][ClkW-1:0]  wrRecover,
  output logic [CntW-1:0]                 setupClks,
  output logic [CntW-1:0]                 drdyClks,
  output logic                            prefetchEn
);
  logic [BusW-1:0]                ctrlReg;
  logic [BusW-1:0]                miscReg;
  logic [NumBanks-1:0][BusW-1:0]  timRdReg;
  logic [NumBanks-1:0][BusW-1:0]  timWrReg;
  logic [BankW-1:0]               accBank;

  // Bank B is reachable only when the control enable bit is set.
  assign accBank = ctrlReg[CtrlBankBEn] ? BankW'(miscReg[MiscBankBit]) : '0;

  for (genvar b = 0; b < NumBanks; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        timRdReg[b] <= TimReset;
        timWrReg[b] <= TimReset;
      end else begin
        if (strb.wrTimRd && accBank == BankW'(b)) timRdReg[b] <= wrData;
        if (strb.wrTimWr && accBank == BankW'(b)) timWrReg[b] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= RegReset;
      miscReg <= RegReset;
    end else begin
      if (strb.wrCtrl) ctrlReg <= wrData;
      if (strb.wrMisc) miscReg <= wrData;
    end
  end

  for (genvar d = 0; d < NumDrives; d++) begin : g_drive
    logic [BankW-1:0] drvBank;
    if (d == 0) begin : g_fixed
      assign drvBank = '0;
    end else begin : g_split
      assign drvBank = ctrlReg[CtrlSplitBit] ? BankW'(d) : '0;
    end
    assign rdActive[d]  = activeOf(timRdReg[drvBank][BusW-1:NibW]);
    assign rdRecover[d] = recoverOf(timRdReg[drvBank][NibW-1:0]);
    assign wrActive[d]  = activeOf(timWrReg[drvBank][BusW-1:NibW]);
    assign wrRecover[d] = recoverOf(timWrReg[drvBank][NibW-1:0]);
  end

  assign setupClks  = CntW'(miscReg[MiscSetupLo +: FieldW]) + CntW'(1);
  assign drdyClks   = CntW'(miscReg[MiscDrdyLo +: FieldW]) + CntW'(2);
  assign prefetchEn = miscReg[MiscPrefBit];

  always_comb begin
    case (strb.rdSel)
      SelTimRd: rdData = timRdReg[accBank];
      SelTimWr: rdData = timWrReg[accBank];
      SelCtrl:  rdData = ctrlReg;
      SelStrap: rdData = strapPins;
      SelMisc:  rdData = miscReg;
      default:  rdData = IdleRead;
    endcase
  end

  // R3
  locked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.open |-> rdData == IdleRead);
  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.open |=> ($stable(ctrlReg) && $stable(miscReg)
                    && $stable(timRdReg) && $stable(timWrReg)));
  // R6
  shared_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[CtrlSplitBit] |-> (rdActive[1] == rdActive[0]
      && rdRecover[1] == rdRecover[0] && wrActive[1] == wrActive[0]
      && wrRecover[1] == wrRecover[0]));
  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdActive[0] != '0) && (wrActive[1] != '0) && (rdRecover[1] >= ClkW'(2)));
endmodule

// File: rtl/pio_timing_bank.sv
module pio_timing_bank
  import pio_bank_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [OffW-1:0]                 busAddr,
  input  logic                            busWrEn,
  input  logic                            busRdEn,
  input  logic [BusW-1:0]                 busWrData,
  output logic [BusW-1:0]                 busRdData,
  input  logic [BusW-1:0]                 strapPins,
  output logic [NumDrives-1:0][ClkW-1:0]  rdActiveClks,
  output logic [NumDrives-1:0][ClkW-1:0]  rdRecoverClks,
  output logic [NumDrives-1:0][ClkW-1:0]  wrActiveClks,
  output logic [NumDrives-1:0][ClkW-1:0]  wrRecoverClks,
  output logic [CntW-1:0]                 setupClks,
  output logic [CntW-1:0]                 drdyClks,
  output logic                            prefetchEn
);
  strobe_t strb;

  pio_bank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .strb(strb)
  );

  pio_bank_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .strapPins(strapPins), .rdData(busRdData),
    .rdActive(rdActiveClks), .rdRecover(rdRecoverClks),
    .wrActive(wrActiveClks), .wrRecover(wrRecoverClks),
    .setupClks(setupClks), .drdyClks(drdyClks), .prefetchEn(prefetchEn)
  );

  // R9
  strap_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.open && busRdEn && busAddr == OffStrap) |-> busRdData == strapPins);
  // R10
  dead_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdEn || busAddr == OffLock || busAddr == 3'd4 || busAddr == 3'd7)
      |-> busRdData == IdleRead);
endmodule

// File: tb/test_pio_timing_bank.sv
module test_pio_timing_bank;
  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [2:0]      busAddr = '0;
  logic            busWrEn = 1'b0;
  logic            busRdEn = 1'b0;
  logic [7:0]      busWrData = '0;
  logic [7:0]      busRdData;
  logic [7:0]      strapPins = 8'h5A;
  logic [1:0][4:0] rdActiveClks, rdRecoverClks, wrActiveClks, wrRecoverClks;
  logic [2:0]      setupClks, drdyClks;
  logic            prefetchEn;

  int  nChk = 0;
  int  nBad = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  pio_timing_bank i_pio_timing_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .strapPins(strapPins), .rdActiveClks(rdActiveClks),
    .rdRecoverClks(rdRecoverClks), .wrActiveClks(wrActiveClks),
    .wrRecoverClks(wrRecoverClks), .setupClks(setupClks),
    .drdyClks(drdyClks), .prefetchEn(prefetchEn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    busAddr = 3'(a); busWrData = 8'(v); busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    busAddr = 3'(a); busRdEn = 1'b1;
    #2 v = int'(busRdData);
    busRdEn = 1'b0;
  endtask

  task automatic chkDrive(input string req, input int d, input int rdB, input int wrB);
    chk({req, " rd active"},   int'(rdActiveClks[d]),  (rdB >> 4) + 1);
    chk({req, " rd recover"},  int'(rdRecoverClks[d]), (rdB & 15) + 2);
    chk({req, " wr active"},   int'(wrActiveClks[d]),  (wrB >> 4) + 1);
    chk({req, " wr recover"},  int'(wrRecoverClks[d]), (wrB & 15) + 2);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", nChk, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkDrive("R1 drive0", 0, 255, 255);
    chkDrive("R1 drive1", 1, 255, 255);
    chk("R1 setup", int'(setupClks), 1);
    chk("R1 drdy", int'(drdyClks), 2);
    chk("R1 prefetch", int'(prefetchEn), 0);
    // R3 closed reads
    for (int a = 0; a < 8; a++) begin
      rd(a, v); chk("R3 closed read", v, 255);
    end

    // R3 closed writes do nothing
    wr(0, 8'h12); wr(1, 8'h34); wr(3, 8'h85); wr(6, 8'h71);
    chkDrive("R3 closed drive0", 0, 255, 255);
    chk("R3 closed setup", int'(setupClks), 1);
    // R2 other key values keep it closed
    wr(2, 8'h00); wr(2, 8'h80); wr(2, 8'h43);
    rd(6, v); chk("R2 stay closed", v, 255);
    wr(2, 8'h03);
    rd(0, v); chk("R3 timing untouched", v, 255);
    rd(1, v); chk("R3 timing untouched", v, 255);
    rd(3, v); chk("R3 ctrl untouched", v, 0);
    rd(6, v); chk("R3 misc untouched", v, 0);
    // R2 non-key write while open keeps it open
    wr(2, 8'h55);
    rd(3, v); chk("R2 stay open", v, 0);

    // R9 strap
    rd(5, v); chk("R9 strap read", v, 8'h5A);
    wr(5, 8'h00);
    rd(5, v); chk("R9 strap write ignored", v, 8'h5A);
    strapPins = 8'hC3;
    rd(5, v); chk("R9 strap follows pins", v, 8'hC3);

    // R10 dead offsets
    wr(4, 8'h11); wr(7, 8'h22);
    rd(2, v); chk("R10 offset2", v, 255);
    rd(4, v); chk("R10 offset4", v, 255);
    rd(7, v); chk("R10 offset7", v, 255);
    rd(3, v); chk("R10 ctrl unchanged", v, 0);
    rd(6, v); chk("R10 misc unchanged", v, 0);
    rd(0, v); chk("R10 timing unchanged", v, 255);
    busAddr = 3'd3; #1 chk("R10 idle bus", int'(busRdData), 255);

    // R4 bank B disabled: misc bit0 alone goes to bank A
    wr(6, 8'h01);
    wr(0, 8'h12); wr(1, 8'h9A);
    chkDrive("R4 bankA via disabled B", 0, 8'h12, 8'h9A);
    wr(3, 8'hC0);
    wr(0, 8'h34); wr(1, 8'h56);
    chkDrive("R4 drive0 stays bankA", 0, 8'h12, 8'h9A);
    // R6 shared map
    chkDrive("R6 drive1 shares A", 1, 8'h12, 8'h9A);
    rd(0, v); chk("R5 bankB read", v, 8'h34);
    rd(1, v); chk("R5 bankB write byte", v, 8'h56);
    wr(6, 8'h00);
    rd(0, v); chk("R5 bankA read", v, 8'h12);
    rd(3, v); chk("R5 ctrl read", v, 8'hC0);
    wr(3, 8'h85);
    chkDrive("R6 drive1 bankB", 1, 8'h34, 8'h56);
    chkDrive("R6 drive0 bankA", 0, 8'h12, 8'h9A);

    // R7 sweep bank A
    for (int b = 0; b < 256; b++) begin
      wr(0, b); wr(1, 255 - b);
      chkDrive("R7 bankA", 0, b, 255 - b);
    end
    rd(0, v); chk("R5 sweep readback", v, 255);
    // R7 sweep bank B
    wr(6, 8'h01);
    for (int b = 0; b < 256; b++) begin
      wr(0, 255 - b); wr(1, b);
      chkDrive("R7 bankB", 1, 255 - b, b);
    end
    chkDrive("R4 bankA kept", 0, 255, 0);

    // R8 misc sweep
    for (int m = 0; m < 128; m++) begin
      wr(6, m);
      chk("R8 setup", int'(setupClks), ((m >> 4) & 3) + 1);
      chk("R8 drdy", int'(drdyClks), ((m >> 1) & 3) + 2);
      chk("R8 prefetch", int'(prefetchEn), (m >> 6) & 1);
      rd(6, v); chk("R5 misc read", v, m);
    end

    // R2 close again
    wr(2, 8'h83);
    rd(6, v); chk("R2 closed read", v, 255);
    wr(6, 8'h00); wr(0, 8'h00);
    chk("R3 closed misc hold", int'(setupClks), 4);
    chk("R3 closed misc hold", int'(drdyClks), 5);
    chk("R3 closed prefetch hold", int'(prefetchEn), 1);
    chkDrive("R3 closed timing hold", 1, 0, 255);
    wr(2, 8'h03);
    rd(6, v); chk("R2 reopen", v, 127);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule